// File: doc/BRIEF.md
# Register-Programmed Byte SPI Master

This block is an SPI master that software drives through a small 32-bit register bus. Storing a word in the transmit register sends one byte on the serial data output while one byte is gathered from the serial data input. Once the exchange is over, the gathered byte can be read back. The serial clock runs in SPI mode 0: it idles low, both sides sample on its rising edge, and the master changes its output on the falling edge. Each half period of the serial clock lasts 2^sel bus clocks, where sel is a 4-bit field that software writes.

Chip select is not driven per transfer. It is a register bit that software sets and clears, so one device can stay selected across any number of bytes. A second control word feeds an external configuration controller. It drives an active-low line that grants this master ownership of the attached storage device, an active-low reconfiguration request, and a 3-bit image slot number.

The bus has no wait states. A write is taken on the rising clock edge at which `bus_req` and `bus_wr` are both high. Read data is combinational from `bus_addr` while `bus_req` is high and `bus_wr` is low. The word index is `bus_addr[5:2]`.

Top module: `sbm_spi_master`

## Requirements
- R1: After reset, every word reads as zero, `spi_cs_n`, `store_own_n` and `cfg_req_n` are high, `cfg_slot`, `spi_sclk` and `xfer_busy` are low, and the divider select is 0.
- R2: The control word at offset 0x0 holds the divider select in bits [3:0] and the chip-select bit in bit 31, and reads back as exactly those bits. A transfer keeps `xfer_busy` high for 16·2^sel bus clocks, so each serial clock half period is 2^sel bus clocks.
- R3: A write to offset 0x4 while idle starts one transfer. `spi_sclk` is low whenever the block is idle. `spi_mosi` carries the byte most significant bit first and is stable at every rising edge of `spi_sclk`.
- R4: `spi_miso` is sampled on each rising edge of `spi_sclk`, most significant bit first. Offset 0x8 reads {24'b0, received byte}, and the value changes only in the cycle in which `xfer_busy` falls.
- R5: A write to offset 0x4 while `xfer_busy` is high is ignored: the byte on the line and the value read back from offset 0x4 are both unchanged.
- R6: `spi_cs_n` is the inverse of bit 31 of offset 0x0. It stays as set across transfers until software writes that bit again.
- R7: At offset 0xC, bit 0 drives `store_own_n` inverted, bit 1 drives `cfg_req_n` inverted, and bits [10:8] appear on `cfg_slot`. That word reads back only those bits.
- R8: Offsets 0x10 to 0x3C are reserved. Writes to them change no register and no output, and reads from them return zero.
- R9: A divider change written during a transfer does not alter that transfer's timing. The next transfer uses the new value.
- R10: Only bits [7:0] of a write to offset 0x4 are sent. Bits [31:8] are dropped, and offset 0x4 reads back {24'b0, byte}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits [5:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| xfer_busy | output | 1 | High while a byte exchange runs |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |
| store_own_n | output | 1 | Storage ownership grant, active low |
| cfg_req_n | output | 1 | Reconfiguration request, active low |
| cfg_slot | output | 3 | Image slot number |

## Verification
The bench exchanges bytes in two directions at once. Alternating, one-hot-high, one-hot-low, all-ones and all-zero bit patterns are sent on the line and returned by a slave model. Any swap of bit order, any off-by-one in the shift, or any mix-up between the transmit and receive paths then shows as a wrong byte. The transfers are timed at divider values 0 to 4, which separates the 2^sel half period from a linear or off-by-one divider. Two writes land in the middle of a transfer, one to the divider and one to the transmit register, to separate latched behaviour from live behaviour. Reserved and control writes then check that the chip select, the side-band lines and the readback stay unchanged.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  // word indices (byte offset / 4) of the live registers
  localparam int unsigned WORD_CFG  = 0;
  localparam int unsigned WORD_TX   = 1;
  localparam int unsigned WORD_RX   = 2;
  localparam int unsigned WORD_SIDE = 3;
  localparam int unsigned LIVE_WORDS = 4;

  // side-band word layout
  localparam int unsigned OWN_BIT  = 0;
  localparam int unsigned REQ_BIT  = 1;
  localparam int unsigned SLOT_LSB = 8;
  localparam int unsigned SLOT_W   = 3;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic              cfg_req;
    logic              own_en;
  } side_t;

  // bus clocks in one serial clock half period
  function automatic int unsigned half_cycles(input int unsigned sel);
    return 32'd1 << sel;
  endfunction

  // bus clocks from start to end of one transfer
  function automatic int unsigned xfer_cycles(input int unsigned sel,
                                              input int unsigned nbits);
    return 2 * nbits * half_cycles(sel);
  endfunction

endpackage

// File: rtl/sbm_clkgen.sv
module sbm_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = 2 ** DIV_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit = CNT_W'(sbm_pkg::half_cycles(int'(sel)) - 1);
    tick  = run && (cnt_q == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: the half-period counter never runs past its limit
  assert_cnt_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));

  // R2: the counter sits at zero while idle
  assert_cnt_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/sbm_shifter.sv
module sbm_shifter #(
  parameter int DIV_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_try,
  input  logic [DATA_W-1:0] start_byte,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte,
  output logic [DIV_W-1:0]  sel_used,
  output logic              done
);
  localparam int HALVES = 2 * DATA_W;
  localparam int HALF_W = $clog2(HALVES);
  localparam logic [HALF_W-1:0] LAST_HALF = HALF_W'(HALVES - 1);

  logic              busy_q, sclk_q;
  logic [HALF_W-1:0] half_q;
  logic [DATA_W-1:0] txs_q, rxs_q, rx_q;
  logic [DIV_W-1:0]  sel_q;
  logic              start_evt;
  logic              rise_evt, fall_evt;

  assign start_evt = start_try && !busy_q;
  assign rise_evt  = busy_q && tick && !sclk_q;
  assign fall_evt  = busy_q && tick && sclk_q;
  assign done      = fall_evt && (half_q == LAST_HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      half_q <= '0;
      txs_q  <= '0;
      rxs_q  <= '0;
      rx_q   <= '0;
      sel_q  <= '0;
    end else if (start_evt) begin
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
      half_q <= '0;
      txs_q  <= start_byte;
      sel_q  <= div_sel;
    end else if (busy_q && tick) begin
      sclk_q <= !sclk_q;
      half_q <= half_q + 1'b1;
      if (rise_evt) begin
        rxs_q <= {rxs_q[DATA_W-2:0], miso};
      end else begin
        txs_q <= {txs_q[DATA_W-2:0], 1'b0};
        if (done) begin
          busy_q <= 1'b0;
          rx_q   <= rxs_q;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign sclk     = sclk_q;
  assign mosi     = txs_q[DATA_W-1];
  assign rx_byte  = rx_q;
  assign sel_used = sel_q;

  // R3: serial clock is low whenever no transfer runs
  assert_sclk_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_q);

  // R3: data out only moves on a falling edge or at start
  assert_mosi_moves_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall_evt) |=> $stable(txs_q));

  // R5: a start attempt during a transfer keeps it running
  assert_busy_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_try && !done) |=> busy_q);

  // R9: the latched divider holds for the whole transfer
  assert_div_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> $stable(sel_q));

  // R4: received byte only changes as busy falls
  assert_rx_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_q != $past(rx_q)) |-> $fell(busy_q));

endmodule

// File: rtl/sbm_regfile.sv
module sbm_regfile #(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic                busy,
  input  logic [DATA_W-1:0]   rx_byte,
  output logic [DIV_W-1:0]    div_sel,
  output logic                cs_on,
  output sbm_pkg::side_t      side,
  output logic                tx_try,
  output logic [DATA_W-1:0]   tx_data,
  output logic                cfg_wr,
  output logic                side_wr,
  output logic                rsvd_wr
);
  import sbm_pkg::*;

  localparam int WORD_W = ADDR_W - 2;
  localparam int CS_BIT = BUS_W - 1;
  localparam logic [WORD_W-1:0] A_CFG  = WORD_W'(WORD_CFG);
  localparam logic [WORD_W-1:0] A_TX   = WORD_W'(WORD_TX);
  localparam logic [WORD_W-1:0] A_RX   = WORD_W'(WORD_RX);
  localparam logic [WORD_W-1:0] A_SIDE = WORD_W'(WORD_SIDE);
  localparam logic [WORD_W-1:0] A_LIVE = WORD_W'(LIVE_WORDS);

  logic [WORD_W-1:0] word;
  logic              wr_evt, rd_evt;
  logic [DIV_W-1:0]  sel_q;
  logic              cs_q;
  logic [DATA_W-1:0] tx_q;
  side_t             side_q;
  logic              unused_bits;

  assign word    = bus_addr[ADDR_W-1:2];
  assign wr_evt  = bus_req && bus_wr;
  assign rd_evt  = bus_req && !bus_wr;
  assign cfg_wr  = wr_evt && (word == A_CFG);
  assign tx_try  = wr_evt && (word == A_TX);
  assign side_wr = wr_evt && (word == A_SIDE);
  assign rsvd_wr = wr_evt && (word >= A_LIVE);
  assign tx_data = bus_wdata[DATA_W-1:0];
  assign unused_bits = ^{bus_wdata, bus_addr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      cs_q   <= 1'b0;
      tx_q   <= '0;
      side_q <= '0;
    end else begin
      if (cfg_wr) begin
        sel_q <= bus_wdata[DIV_W-1:0];
        cs_q  <= bus_wdata[CS_BIT];
      end
      if (tx_try && !busy) begin
        tx_q <= bus_wdata[DATA_W-1:0];
      end
      if (side_wr) begin
        side_q.own_en  <= bus_wdata[OWN_BIT];
        side_q.cfg_req <= bus_wdata[REQ_BIT];
        side_q.slot    <= bus_wdata[SLOT_LSB +: SLOT_W];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_evt) begin
      case (word)
        A_CFG: begin
          bus_rdata[CS_BIT]      = cs_q;
          bus_rdata[DIV_W-1:0]   = sel_q;
        end
        A_TX:  bus_rdata[DATA_W-1:0] = tx_q;
        A_RX:  bus_rdata[DATA_W-1:0] = rx_byte;
        A_SIDE: begin
          bus_rdata[OWN_BIT]            = side_q.own_en;
          bus_rdata[REQ_BIT]            = side_q.cfg_req;
          bus_rdata[SLOT_LSB +: SLOT_W] = side_q.slot;
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  assign div_sel = sel_q;
  assign cs_on   = cs_q;
  assign side    = side_q;

  // R8: reserved writes leave every live register untouched
  assert_rsvd_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_wr |=> ($stable(sel_q) && $stable(cs_q) && $stable(tx_q) && $stable(side_q)));

  // R5: transmit readback holds while a transfer runs
  assert_tx_hold_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tx_q));

  // R8: reserved reads return zero
  assert_rsvd_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && (word >= A_LIVE)) |-> (bus_rdata == '0));

endmodule

// File: rtl/sbm_spi_master.sv
module sbm_spi_master #(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_req,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [BUS_W-1:0]           bus_wdata,
  output logic [BUS_W-1:0]           bus_rdata,
  output logic                       xfer_busy,
  output logic                       spi_sclk,
  output logic                       spi_mosi,
  input  logic                       spi_miso,
  output logic                       spi_cs_n,
  output logic                       store_own_n,
  output logic                       cfg_req_n,
  output logic [sbm_pkg::SLOT_W-1:0] cfg_slot
);
  import sbm_pkg::*;

  logic              busy, tick, done;
  logic              tx_try, cfg_wr, side_wr, rsvd_wr, cs_on;
  logic [DATA_W-1:0] tx_data, rx_byte;
  logic [DIV_W-1:0]  div_sel, sel_used;
  side_t             side;

  sbm_regfile #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .rx_byte(rx_byte),
    .div_sel(div_sel), .cs_on(cs_on), .side(side),
    .tx_try(tx_try), .tx_data(tx_data),
    .cfg_wr(cfg_wr), .side_wr(side_wr), .rsvd_wr(rsvd_wr)
  );

  sbm_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .sel(sel_used), .tick(tick)
  );

  sbm_shifter #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .start_try(tx_try), .start_byte(tx_data), .div_sel(div_sel),
    .tick(tick), .miso(spi_miso),
    .busy(busy), .sclk(spi_sclk), .mosi(spi_mosi),
    .rx_byte(rx_byte), .sel_used(sel_used), .done(done)
  );

  assign xfer_busy   = busy;
  assign spi_cs_n    = !cs_on;
  assign store_own_n = !side.own_en;
  assign cfg_req_n   = !side.cfg_req;
  assign cfg_slot    = side.slot;

  // R6: chip select holds through a transfer unless software rewrites it
  assert_cs_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_wr) |=> $stable(spi_cs_n));

  // R7: side-band lines move only after a side-band write
  assert_side_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ({store_own_n, cfg_req_n, cfg_slot} != $past({store_own_n, cfg_req_n, cfg_slot}))
      |-> $past(side_wr));

  // R4: a finished transfer always drops busy next cycle
  assert_done_drops_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: tb/tb_sbm_spi_master.sv
module tb_sbm_spi_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        xfer_busy, spi_sclk, spi_mosi, spi_cs_n, store_own_n, cfg_req_n;
  logic        spi_miso = 1'b0;
  logic [2:0]  cfg_slot;

  sbm_spi_master dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_busy(xfer_busy), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .store_own_n(store_own_n),
    .cfg_req_n(cfg_req_n), .cfg_slot(cfg_slot)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  logic [7:0] slv_sr = '0;
  logic [7:0] mon_sr = '0;
  int mon_n = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_req = 1'b0;
  endtask

  function automatic int expected_cycles(input int sel);
    int half = 1;
    for (int i = 0; i < sel; i++) half = half * 2;
    return 16 * half;
  endfunction

  // slave model: shifts its byte out on falling serial clock
  always @(negedge spi_sclk) begin
    slv_sr = {slv_sr[6:0], 1'b0};
    spi_miso = slv_sr[7];
  end

  // monitor: gathers line bytes and compares against the scoreboard
  initial begin
    forever begin
      @(posedge spi_sclk);
      mon_sr = {mon_sr[6:0], spi_mosi};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected line byte", {24'b0, mon_sr}, 32'h0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(mon_sr == e, "R3", "mosi byte", {24'b0, mon_sr}, {24'b0, e});
        end
      end
    end
  end

  // driver: one byte exchange, optional bus write in the middle
  task automatic xfer(input logic [31:0] txw, input logic [7:0] sb, input int sel,
                      input bit mid, input logic [5:0] mid_a, input logic [31:0] mid_d);
    int cnt = 0;
    logic [31:0] rd;
    exp_q.push_back(txw[7:0]);
    slv_sr = sb;
    spi_miso = sb[7];
    bus_write(6'h04, txw);
    fork
      begin
        while (xfer_busy) begin
          cnt++;
          @(negedge clk);
        end
      end
      begin
        if (mid) begin
          repeat (3) @(negedge clk);
          bus_write(mid_a, mid_d);
        end
      end
    join
    check(cnt == expected_cycles(sel), "R2", "busy length", cnt, expected_cycles(sel));
    bus_read(6'h08, rd);
    check(rd == {24'b0, sb}, "R4", "received byte", rd, {24'b0, sb});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check(spi_cs_n && store_own_n && cfg_req_n, "R1", "active-low lines high",
          {29'b0, spi_cs_n, store_own_n, cfg_req_n}, 32'h7);
    check(cfg_slot == 0 && !spi_sclk && !xfer_busy, "R1", "slot/sclk/busy low",
          {28'b0, cfg_slot, spi_sclk | xfer_busy}, 32'h0);
    for (int a = 0; a < 16; a += 4) begin
      bus_read(6'(a), rd);
      check(rd == 0, "R1", "reset readback", rd, 32'h0);
    end

    // R6: chip select on, then two bytes with it held
    bus_write(6'h00, 32'h8000_0000);
    check(!spi_cs_n, "R6", "cs asserted", {31'b0, spi_cs_n}, 32'h0);
    bus_read(6'h00, rd);
    check(rd == 32'h8000_0000, "R2", "cfg readback", rd, 32'h8000_0000);
    xfer(32'h0000_00A5, 8'h3C, 0, 0, 6'h0, 32'h0);
    xfer(32'h0000_0001, 8'h80, 0, 0, 6'h0, 32'h0);
    check(!spi_cs_n, "R6", "cs held across bytes", {31'b0, spi_cs_n}, 32'h0);

    // R2 masking of unused cfg bits; R10 upper tx bits dropped
    bus_write(6'h00, 32'hFFFF_FFF2);
    bus_read(6'h00, rd);
    check(rd == 32'h8000_0002, "R2", "cfg masked readback", rd, 32'h8000_0002);
    xfer(32'hABCD_EF5A, 8'hFF, 2, 0, 6'h0, 32'h0);
    bus_read(6'h04, rd);
    check(rd == 32'h0000_005A, "R10", "tx readback low byte only", rd, 32'h5A);

    // R9: divider change mid-transfer applies only to the next one
    bus_write(6'h00, 32'h8000_0001);
    xfer(32'h0000_0096, 8'h69, 1, 1, 6'h00, 32'h8000_0003);
    xfer(32'h0000_0000, 8'h81, 3, 0, 6'h0, 32'h0);

    // R5: tx write while busy is ignored
    bus_write(6'h00, 32'h8000_0000);
    xfer(32'h0000_003C, 8'hC3, 0, 1, 6'h04, 32'h0000_00FF);
    bus_read(6'h04, rd);
    check(rd == 32'h0000_003C, "R5", "tx kept during busy", rd, 32'h3C);

    bus_write(6'h00, 32'h8000_0004);
    xfer(32'h0000_007E, 8'h00, 4, 0, 6'h0, 32'h0);

    // R6: chip select released
    bus_write(6'h00, 32'h0000_0000);
    check(spi_cs_n, "R6", "cs released", {31'b0, spi_cs_n}, 32'h1);

    // R7: side-band lines
    bus_write(6'h0C, 32'h0000_0503);
    check({store_own_n, cfg_req_n, cfg_slot} == 5'b00_101, "R7", "own+req on, slot 5",
          {27'b0, store_own_n, cfg_req_n, cfg_slot}, 32'h05);
    bus_write(6'h0C, 32'hFFFF_FFFE);
    check({store_own_n, cfg_req_n, cfg_slot} == 5'b10_111, "R7", "own off, req on, slot 7",
          {27'b0, store_own_n, cfg_req_n, cfg_slot}, 32'h17);
    bus_read(6'h0C, rd);
    check(rd == 32'h0000_0702, "R7", "side readback masked", rd, 32'h702);

    // R8: reserved offsets are inert and read zero
    bus_write(6'h10, 32'hFFFF_FFFF);
    bus_write(6'h24, 32'hFFFF_FFFF);
    bus_write(6'h3C, 32'hFFFF_FFFF);
    check(!xfer_busy && spi_cs_n, "R8", "no transfer, cs unchanged",
          {30'b0, xfer_busy, spi_cs_n}, 32'h1);
    check({store_own_n, cfg_req_n, cfg_slot} == 5'b10_111, "R8", "side lines unchanged",
          {27'b0, store_own_n, cfg_req_n, cfg_slot}, 32'h17);
    bus_read(6'h00, rd);
    check(rd == 32'h0, "R8", "cfg unchanged", rd, 32'h0);
    bus_read(6'h0C, rd);
    check(rd == 32'h0000_0702, "R8", "side unchanged", rd, 32'h702);
    bus_read(6'h08, rd);
    check(rd == 32'h0, "R8", "rx unchanged", rd, 32'h0);
    bus_read(6'h10, rd);
    check(rd == 32'h0, "R8", "reserved 0x10 reads zero", rd, 32'h0);
    bus_read(6'h3C, rd);
    check(rd == 32'h0, "R8", "reserved 0x3C reads zero", rd, 32'h0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3", "all expected bytes seen", exp_q.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule